// File: doc/BRIEF.md
# Dual-Edge GPIO Interrupt Port

A sixteen-pin general-purpose I/O port controlled through seven halfword registers. Each pin has a direction bit. Output pins drive the value held in an output-data register. Input pins pass through a synchronizer, and every change between two consecutive synchronized samples counts as a rising or a falling edge. Each pin has its own enable for rising edges and its own enable for falling edges. An enabled edge latches a sticky status bit. Software clears a status bit by writing a one to it. The masked status of all pins merges into one registered interrupt line.

The register lane is big-endian. The high byte of every logical halfword travels on bus bits 7:0 and the low byte on bus bits 15:8, in both directions. A host on a little-endian bus therefore sees each value byte-swapped. The port also decodes a socket-presence flag from two active-low detect pins. The flag is asserted only when both of those synchronized pins read 0.

Top module: `gpio_edge_port`

## Requirements
- R1: Register offsets on `bus_addr` are 0 direction, 1 synchronized input, 2 output data, 3 rising enable, 4 falling enable, 5 rising status and 6 falling status. Each register is written on a clock with `bus_we` high. For reads and writes the logical value L appears on the bus as {L[7:0], L[15:8]}. Read data is combinational from `bus_addr`.
- R2: `pin_oe` equals the direction register, where bit value 1 means output. `pin_out` equals the output-data register. Both change on the clock edge that takes the write.
- R3: Offset 1 reads `pin_in` after two synchronizing flops, so a pin change is visible after the second rising clock edge. A pin whose direction bit is 1 never produces an edge event.
- R4: A rising edge is a 0-to-1 change between consecutive synchronized samples. When that pin's rising-enable bit is set, the edge sets its rising-status bit on the third clock edge after the pin changed. With the enable clear, nothing is recorded.
- R5: Falling edges (1 to 0) set the falling-status bit under the falling-enable bit alone. A pin enabled for falling edges only records nothing on a rising edge.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an enabled edge and a clearing write reach the same bit on the same clock, the bit ends up set.
- R7: `irq` is a flop that, one clock after the status registers change, holds the OR over all pins of (rising status AND rising enable) OR (falling status AND falling enable).
- R8: `slot_present` is 1 exactly when the synchronized detect pins (default bits 8 and 9) are both 0. It follows `pin_in` after two clock edges.
- R9: Writes to offset 1 and offset 7 change nothing. Offset 7 reads 0.
- R10: Synchronous active-high reset clears the direction, output data, enables, statuses, synchronizers and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data, byte-swapped lane |
| bus_rdata | output | 16 | Read data, byte-swapped lane |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 1 | Combined edge interrupt |
| slot_present | output | 1 | Both detect pins low |

## Verification
The results are due at different clock edges:
- Register, `pin_out` and `pin_oe` updates appear on the edge that samples the write.
- Synchronized input data and `slot_present` appear two edges after a pin change.
- Status bits appear three edges after a pin change.
- `irq` appears one edge after the status bits.

The bench drives inputs on falling edges. A behavioural model steps on each rising edge, keeping the pin history in a queue and tapping it at the matching depth. All outputs are compared 1 ns after that edge. The directed checks wait the stated number of edges before reading. The set-wins case lines the clearing write up with exactly the third edge after the pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PORT_W  = 2 * BYTE_W;
    localparam int unsigned ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DIR     = 3'd0,
        OFS_PIN     = 3'd1,
        OFS_DOUT    = 3'd2,
        OFS_RISE_EN = 3'd3,
        OFS_FALL_EN = 3'd4,
        OFS_RISE_ST = 3'd5,
        OFS_FALL_ST = 3'd6,
        OFS_NONE    = 3'd7
    } gpio_ofs_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] dout;
        logic [PORT_W-1:0] rise_en;
        logic [PORT_W-1:0] fall_en;
    } gpio_ctl_t;

    typedef struct packed {
        logic              we;
        gpio_ofs_e         ofs;
        logic [PORT_W-1:0] data;
    } gpio_wr_t;

    // Big-endian lane: exchange the two bytes of a halfword.
    function automatic logic [PORT_W-1:0] lane_swap(input logic [PORT_W-1:0] v);
        return {v[BYTE_W-1:0], v[PORT_W-1:BYTE_W]};
    endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W      = PORT_W,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_async,
    input  logic [W-1:0] pin_is_out,
    output logic [W-1:0] pin_sync,
    output logic [W-1:0] rise_evt,
    output logic [W-1:0] fall_evt
);

    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= '0;
                else     chain_q[g] <= pin_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= '0;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign pin_sync = chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_sync;
    end

    // Edges only count on pins configured as inputs.
    assign rise_evt =  pin_sync & ~prev_q & ~pin_is_out;
    assign fall_evt = ~pin_sync &  prev_q & ~pin_is_out;

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] en,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat
);

    // Clear first, then set: an edge in the same cycle wins.
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr) | (evt & en);
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_edge_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gpio_wr_t  wr,
    output gpio_ctl_t ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr.we) begin
            case (wr.ofs)
                OFS_DIR:     ctl.dir     <= wr.data;
                OFS_DOUT:    ctl.dout    <= wr.data;
                OFS_RISE_EN: ctl.rise_en <= wr.data;
                OFS_FALL_EN: ctl.fall_en <= wr.data;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DETECT_A    = 8,
    parameter int unsigned DETECT_B    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic              irq,
    output logic              slot_present
);

    localparam int unsigned NPOL = 2;   // index 0 rising, 1 falling

    gpio_wr_t          wr;
    gpio_ctl_t         ctl;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] rise_evt, fall_evt;
    logic [PORT_W-1:0] evt_pol  [NPOL];
    logic [PORT_W-1:0] en_pol   [NPOL];
    logic [PORT_W-1:0] clr_pol  [NPOL];
    logic [PORT_W-1:0] stat_pol [NPOL];
    logic [PORT_W-1:0] rd_log;

    always_comb begin
        wr.we   = bus_we;
        wr.ofs  = gpio_ofs_e'(bus_addr);
        wr.data = lane_swap(bus_wdata);
    end

    gpio_regfile u_regs (
        .clk (clk),
        .rst (rst),
        .wr  (wr),
        .ctl (ctl)
    );

    gpio_sync_edge #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_async  (pin_in),
        .pin_is_out (ctl.dir),
        .pin_sync   (pin_sync),
        .rise_evt   (rise_evt),
        .fall_evt   (fall_evt)
    );

    always_comb begin
        evt_pol[0] = rise_evt;
        evt_pol[1] = fall_evt;
        en_pol[0]  = ctl.rise_en;
        en_pol[1]  = ctl.fall_en;
        clr_pol[0] = (wr.we && wr.ofs == OFS_RISE_ST) ? wr.data : '0;
        clr_pol[1] = (wr.we && wr.ofs == OFS_FALL_ST) ? wr.data : '0;
    end

    for (genvar p = 0; p < NPOL; p++) begin : g_pol
        gpio_edge_status #(.W(PORT_W)) u_stat (
            .clk  (clk),
            .rst  (rst),
            .evt  (evt_pol[p]),
            .en   (en_pol[p]),
            .clr  (clr_pol[p]),
            .stat (stat_pol[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |((stat_pol[0] & en_pol[0]) | (stat_pol[1] & en_pol[1]));
    end

    always_comb begin
        case (wr.ofs)
            OFS_DIR:     rd_log = ctl.dir;
            OFS_PIN:     rd_log = pin_sync;
            OFS_DOUT:    rd_log = ctl.dout;
            OFS_RISE_EN: rd_log = ctl.rise_en;
            OFS_FALL_EN: rd_log = ctl.fall_en;
            OFS_RISE_ST: rd_log = stat_pol[0];
            OFS_FALL_ST: rd_log = stat_pol[1];
            default:     rd_log = '0;
        endcase
    end

    assign bus_rdata    = lane_swap(rd_log);
    assign pin_out      = ctl.dout;
    assign pin_oe       = ctl.dir;
    assign slot_present = ~pin_sync[DETECT_A] & ~pin_sync[DETECT_B];

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] pin_oe,
    input logic        irq,
    input logic [15:0] dir,
    input logic [15:0] rise_en,
    input logic [15:0] fall_en,
    input logic [15:0] rise_st,
    input logic [15:0] fall_st,
    input logic [15:0] rise_evt
);

    logic [15:0] wlog;
    logic [15:0] masked;
    assign wlog   = {bus_wdata[7:0], bus_wdata[15:8]};
    assign masked = (rise_st & rise_en) | (fall_st & fall_en);

    a_r1_dir_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd0) |=> (pin_oe == $past(wlog)));

    a_r3_no_status_on_output: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise_st & ~$past(rise_st) & $past(dir)) == 16'h0));

    a_r4_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise_st & ~$past(rise_st) & ~$past(rise_en)) == 16'h0));

    a_r5_fall_needs_enable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fall_st & ~$past(fall_st) & ~$past(fall_en)) == 16'h0));

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd5) |=>
            ((rise_st & $past(wlog) & ~$past(rise_evt & rise_en)) == 16'h0));

    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (masked == 16'h0) |=> !irq);

    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(masked) != 16'h0));

endmodule

bind gpio_edge_port gpio_edge_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .dir      (ctl.dir),
    .rise_en  (ctl.rise_en),
    .fall_en  (ctl.fall_en),
    .rise_st  (stat_pol[0]),
    .fall_st  (stat_pol[1]),
    .rise_evt (rise_evt)
);

// File: tb/gpio_edge_port_tb.sv
`timescale 1ns/100ps
module gpio_edge_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = 16'h0;
    logic [15:0] pin_out, pin_oe;
    logic        irq, slot_present;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_port u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .slot_present(slot_present)
    );

    function automatic logic [15:0] sw(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_dir, m_dout, m_ren, m_fen, m_rst, m_fst;
    logic        m_irq;
    logic [15:0] hist [$];

    always @(posedge clk) begin
        logic        s_rst, s_we;
        logic [2:0]  s_addr;
        logic [15:0] s_wd, s_pin, wl, s2, pv, rise, fall, crs, cfs, exp_rd;
        logic        nirq;
        string       tag;
        int          n;
        s_rst = rst; s_we = bus_we; s_addr = bus_addr; s_wd = bus_wdata; s_pin = pin_in;
        if (s_rst) begin
            m_dir = 0; m_dout = 0; m_ren = 0; m_fen = 0; m_rst = 0; m_fst = 0; m_irq = 0;
            hist = '{16'h0, 16'h0, 16'h0};
        end else begin
            n    = hist.size();
            s2   = hist[n-2];
            pv   = hist[n-3];
            rise =  s2 & ~pv & ~m_dir;
            fall = ~s2 &  pv & ~m_dir;
            wl   = sw(s_wd);
            crs  = (s_we && s_addr == 3'd5) ? wl : 16'h0;
            cfs  = (s_we && s_addr == 3'd6) ? wl : 16'h0;
            nirq = |((m_rst & m_ren) | (m_fst & m_fen));
            m_rst = (m_rst & ~crs) | (rise & m_ren);
            m_fst = (m_fst & ~cfs) | (fall & m_fen);
            m_irq = nirq;
            if (s_we) begin
                case (s_addr)
                    3'd0: m_dir  = wl;
                    3'd2: m_dout = wl;
                    3'd3: m_ren  = wl;
                    3'd4: m_fen  = wl;
                    default: ;
                endcase
            end
            hist.push_back(s_pin);
            if (hist.size() > 3) void'(hist.pop_front());
        end
        #1;
        if (!s_rst && !done) begin
            n = hist.size();
            case (bus_addr)
                3'd0: begin exp_rd = m_dir;     tag = "R1 dir read"; end
                3'd1: begin exp_rd = hist[n-2]; tag = "R3 input read"; end
                3'd2: begin exp_rd = m_dout;    tag = "R1 dout read"; end
                3'd3: begin exp_rd = m_ren;     tag = "R1 rise_en read"; end
                3'd4: begin exp_rd = m_fen;     tag = "R1 fall_en read"; end
                3'd5: begin exp_rd = m_rst;     tag = "R4 rise status read"; end
                3'd6: begin exp_rd = m_fst;     tag = "R5 fall status read"; end
                default: begin exp_rd = 16'h0;  tag = "R9 offset 7 read"; end
            endcase
            chk(tag, bus_rdata, sw(exp_rd));
            chk("R2 pin_oe", pin_oe, m_dir);
            chk("R2 pin_out", pin_out, m_dout);
            chk("R7 irq", {15'h0, irq}, {15'h0, m_irq});
            chk("R8 slot_present", {15'h0, slot_present},
                {15'h0, ~hist[n-2][8] & ~hist[n-2][9]});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = sw(v);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 16'h0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = sw(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd(3'd0, v); chk("R10 dir after reset", v, 16'h0);
        rd(3'd5, v); chk("R10 rise status after reset", v, 16'h0);
        chk("R10 irq after reset", {15'h0, irq}, 16'h0);
        chk("R10 pin_oe after reset", pin_oe, 16'h0);

        // R1 / R2 writes and byte lanes
        wr(3'd0, 16'h00F0);
        wr(3'd2, 16'hA5C3);
        chk("R2 pin_oe direct", pin_oe, 16'h00F0);
        chk("R2 pin_out direct", pin_out, 16'hA5C3);
        @(negedge clk); bus_addr = 3'd2; #1;
        chk("R1 raw lane of dout", bus_rdata, 16'hC3A5);

        // R4 rising edge, R5 falling only on bit1
        wr(3'd3, 16'h0001);
        wr(3'd4, 16'h0002);
        @(negedge clk); pin_in[0] = 1'b1; pin_in[1] = 1'b1;
        idle(5);
        rd(3'd5, v); chk("R4 rise status bit0 set", v, 16'h0001);
        rd(3'd6, v); chk("R5 no fall status on rise", v, 16'h0000);
        chk("R7 irq raised", {15'h0, irq}, 16'h1);
        @(negedge clk); pin_in[1] = 1'b0;
        idle(5);
        rd(3'd6, v); chk("R5 fall status bit1 set", v, 16'h0002);
        rd(3'd5, v); chk("R5 rise status unaffected", v, 16'h0001);

        // R6 write-one-to-clear
        wr(3'd5, 16'h0000);
        rd(3'd5, v); chk("R6 zero write keeps bit", v, 16'h0001);
        wr(3'd5, 16'h0001);
        wr(3'd6, 16'h0002);
        rd(3'd5, v); chk("R6 one write clears bit", v, 16'h0000);
        idle(2);
        chk("R7 irq drops after clear", {15'h0, irq}, 16'h0);

        // R3 output pin produces no edge
        wr(3'd3, 16'h0011);
        @(negedge clk); pin_in[4] = 1'b1;
        idle(5);
        rd(3'd5, v); chk("R3 no status on output pin", v, 16'h0000);
        rd(3'd1, v); chk("R3 synchronized input visible", v, 16'h0011);

        // R6 set wins over simultaneous clear
        @(negedge clk); pin_in[0] = 1'b0;
        idle(5);
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = sw(16'h0001);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 16'h0;
        rd(3'd5, v); chk("R6 edge wins over clear", v, 16'h0001);
        wr(3'd5, 16'h0001);

        // R9 read-only and unused offsets
        wr(3'd1, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        rd(3'd7, v); chk("R9 offset 7 reads zero", v, 16'h0000);
        rd(3'd0, v); chk("R9 dir unchanged", v, 16'h00F0);

        // R8 presence decode
        @(negedge clk); pin_in[9:8] = 2'b11; idle(3);
        chk("R8 both high empty", {15'h0, slot_present}, 16'h0);
        @(negedge clk); pin_in[9:8] = 2'b01; idle(3);
        chk("R8 one high empty", {15'h0, slot_present}, 16'h0);
        @(negedge clk); pin_in[9:8] = 2'b10; idle(3);
        chk("R8 other high empty", {15'h0, slot_present}, 16'h0);
        @(negedge clk); pin_in[9:8] = 2'b00; idle(3);
        chk("R8 both low present", {15'h0, slot_present}, 16'h1);

        // mixed stress, model compared every clock (R3 R4 R5 R6 R7)
        wr(3'd3, 16'hFF0F);
        wr(3'd4, 16'h0FFF);
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 3 == 0) pin_in = lfsr;
            bus_addr = 3'(i % 8);
            if (i % 17 == 0) begin
                bus_we = 1'b1; bus_addr = (i % 2 == 0) ? 3'd5 : 3'd6;
                bus_wdata = sw(lfsr ^ 16'h5A5A);
            end else begin
                bus_we = 1'b0;
            end
        end
        @(negedge clk); bus_we = 1'b0;
        idle(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule